// File: doc/BRIEF.md
# Indirect CSR Write Bridge

This block lets a host reach a bank of internal 32-bit control/status registers through a few host registers. The host window has four parts: a data register, a command register, a read port for both, and a sixteen-word direct window. Writes come in three forms. A single indirect write is started by a command word with the busy bit set. A sequential write is started by each data-register write once the command register has been armed for stepping, and the stored address moves up or down after every completed cycle. A direct-window write is translated into a full-word write to a fixed internal address that a parameter table selects.

Every accepted trigger loads the same command engine. The engine drives an internal register bus with address, byte enables, write data and a strobe. The strobe stays high until a single-cycle acknowledge comes back. Completion shows as the busy bit dropping in the command register.

Host word addresses: data register at 0x00, command register at 0x01, direct window at 0x10 to 0x1F. The command word layout is: bit 31 busy, bit 30 read-not-write, bit 29 step-up, bit 28 step-down, bits 19:16 byte enables, bits 15:0 target address. Bits 27:20 are not stored and read as zero.

Top module: `csr_write_bridge`

## Requirements
- R1: After reset the strobe is low, and both the data register and the command register read back as zero.
- R2: A write to the data register (0x00) while stepping is not armed, or while bit 30 is set, stores the word and starts no bus cycle.
- R3: A command write (0x01) with bit 31 set and bit 30 clear raises reg_stb one clock later. The bus then carries address bits 15:0, byte enables bits 19:16 and the stored data word.
- R4: While reg_stb is high without reg_ack, the strobe and the address, byte enables and data stay unchanged. On the edge that samples reg_ack, busy clears and the strobe falls.
- R5: A command write with bit 31 and bit 30 both set stores the fields, starts no cycle and reads back with bit 31 clear.
- R6: With bit 29 (step-up) set alone, a data-register write starts a cycle, and on completion the stored address is one higher.
- R7: With bit 28 (step-down) set alone, the stored address is one lower after each completed cycle.
- R8: With bits 29 and 28 both set, data-register writes still start cycles, but the stored address does not change.
- R9: A write to window word 0x10+k starts a cycle. The cycle carries map entry k as the address, byte enables 4'hF and the written word. The command register reads back with bits 30:28 clear.
- R10: While busy, writes to the data register, the command register and the window are ignored. The payload in flight and the later readback are not changed by them.
- R11: Stepping is modulo 2^16: step-up from 0xFFFF gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | HA_W | Host word address of the write |
| host_wdata | input | 32 | Host write data |
| host_rd_addr | input | HA_W | Host word address for readback |
| host_rdata | output | 32 | Data or command register readback (zero elsewhere) |
| reg_addr | output | 16 | Internal register address |
| reg_be | output | 4 | Internal byte enables |
| reg_wdata | output | 32 | Internal write data |
| reg_stb | output | 1 | Internal write strobe, high while busy |
| reg_ack | input | 1 | Single-cycle completion from the register bank |

## Verification
The strobe and bus payload are due one clock after the edge that samples an accepted host write. The bench checks them at the next falling edge, and again after a few idle cycles to catch any drift while no acknowledge has come. Busy clearing and the stepped address are due on the edge that samples the acknowledge. They are read through the host readback port at the falling edge after it. Ignored writes are issued mid-cycle, and their absence of effect is confirmed both on the bus and in the readback after completion.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;
  localparam int ADDR_W = 16;
  localparam int BE_W   = 4;
  localparam int DATA_W = 32;
  localparam int NWIN   = 16;
  localparam int WIDX_W = $clog2(NWIN);

  // command word bit positions
  localparam int BIT_BUSY = 31;
  localparam int BIT_RNW  = 30;
  localparam int BIT_UP   = 29;
  localparam int BIT_DN   = 28;
  localparam int BE_LSB   = 16;

  typedef struct packed {
    logic              busy;
    logic              rnw;
    logic              up;
    logic              dn;
    logic [BE_W-1:0]   be;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  typedef enum logic [1:0] {HIT_NONE, HIT_DATA, HIT_CMD, HIT_WIN} hit_e;

  function automatic cmd_t word_to_cmd(input logic [DATA_W-1:0] w);
    cmd_t c;
    c.busy = w[BIT_BUSY];
    c.rnw  = w[BIT_RNW];
    c.up   = w[BIT_UP];
    c.dn   = w[BIT_DN];
    c.be   = w[BE_LSB +: BE_W];
    c.addr = w[ADDR_W-1:0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cmd_to_word(input cmd_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_BUSY] = c.busy;
    w[BIT_RNW]  = c.rnw;
    w[BIT_UP]   = c.up;
    w[BIT_DN]   = c.dn;
    w[BE_LSB +: BE_W] = c.be;
    w[ADDR_W-1:0] = c.addr;
    return w;
  endfunction

  function automatic logic [NWIN*ADDR_W-1:0] default_win_map();
    logic [NWIN*ADDR_W-1:0] m;
    for (int k = 0; k < NWIN; k++) m[k*ADDR_W +: ADDR_W] = ADDR_W'(16'h0A00 + k * 16);
    return m;
  endfunction
endpackage

// File: rtl/csr_host_decode.sv
module csr_host_decode
  import csr_bridge_pkg::*;
#(
  parameter int              HA_W      = 8,
  parameter logic [HA_W-1:0] DATA_ADDR = 8'h00,
  parameter logic [HA_W-1:0] CMD_ADDR  = 8'h01,
  parameter logic [HA_W-1:0] WIN_BASE  = 8'h10
) (
  input  logic              wr_en,
  input  logic [HA_W-1:0]   addr,
  output hit_e              hit,
  output logic [WIDX_W-1:0] win_idx
);
  logic win_sel;

  assign win_sel = (addr[HA_W-1:WIDX_W] == WIN_BASE[HA_W-1:WIDX_W]);
  assign win_idx = addr[WIDX_W-1:0];

  always_comb begin
    hit = HIT_NONE;
    if (wr_en) begin
      if (win_sel)                hit = HIT_WIN;
      else if (addr == CMD_ADDR)  hit = HIT_CMD;
      else if (addr == DATA_ADDR) hit = HIT_DATA;
    end
  end
endmodule

// File: rtl/csr_win_map.sv
module csr_win_map
  import csr_bridge_pkg::*;
#(
  parameter logic [NWIN*ADDR_W-1:0] WIN_MAP = default_win_map()
) (
  input  logic [WIDX_W-1:0] idx,
  output logic [ADDR_W-1:0] tgt_addr
);
  logic [ADDR_W-1:0] entry [NWIN];

  for (genvar k = 0; k < NWIN; k++) begin : g_entry
    assign entry[k] = WIN_MAP[k*ADDR_W +: ADDR_W];
  end

  assign tgt_addr = entry[idx];
endmodule

// File: rtl/csr_cmd_engine.sv
module csr_cmd_engine
  import csr_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  hit_e              hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] win_addr,
  input  logic              ack,
  output logic [DATA_W-1:0] data_q,
  output cmd_t              cmd_q
);
  logic [DATA_W-1:0] data_d;
  cmd_t              cmd_d;
  logic              data_en;
  logic              cmd_en;

  always_comb begin
    data_d  = data_q;
    cmd_d   = cmd_q;
    data_en = 1'b0;
    cmd_en  = 1'b0;
    if (cmd_q.busy) begin
      if (ack) begin
        cmd_en     = 1'b1;
        cmd_d.busy = 1'b0;
        if (cmd_q.up && !cmd_q.dn)      cmd_d.addr = cmd_q.addr + 1'b1;
        else if (cmd_q.dn && !cmd_q.up) cmd_d.addr = cmd_q.addr - 1'b1;
      end
    end else begin
      unique case (hit)
        HIT_WIN: begin
          data_en    = 1'b1;
          data_d     = wdata;
          cmd_en     = 1'b1;
          cmd_d.addr = win_addr;
          cmd_d.be   = '1;
          cmd_d.rnw  = 1'b0;
          cmd_d.up   = 1'b0;
          cmd_d.dn   = 1'b0;
          cmd_d.busy = 1'b1;
        end
        HIT_CMD: begin
          cmd_en     = 1'b1;
          cmd_d      = word_to_cmd(wdata);
          cmd_d.busy = wdata[BIT_BUSY] && !wdata[BIT_RNW];
        end
        HIT_DATA: begin
          data_en = 1'b1;
          data_d  = wdata;
          if ((cmd_q.up || cmd_q.dn) && !cmd_q.rnw) begin
            cmd_en     = 1'b1;
            cmd_d.busy = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (data_en) data_q <= data_d;
      if (cmd_en)  cmd_q  <= cmd_d;
    end
  end
endmodule

// File: rtl/csr_write_bridge.sv
module csr_write_bridge
  import csr_bridge_pkg::*;
#(
  parameter int                     HA_W      = 8,
  parameter logic [HA_W-1:0]        DATA_ADDR = 8'h00,
  parameter logic [HA_W-1:0]        CMD_ADDR  = 8'h01,
  parameter logic [HA_W-1:0]        WIN_BASE  = 8'h10,
  parameter logic [NWIN*ADDR_W-1:0] WIN_MAP   = default_win_map()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [HA_W-1:0]   host_rd_addr,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BE_W-1:0]   reg_be,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_stb,
  input  logic              reg_ack
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  hit_e              hit;
  logic              win_hit;
  logic [WIDX_W-1:0] win_idx;
  logic [ADDR_W-1:0] win_addr;
  logic [DATA_W-1:0] data_q;
  cmd_t              cmd_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  csr_host_decode #(
    .HA_W(HA_W), .DATA_ADDR(DATA_ADDR), .CMD_ADDR(CMD_ADDR), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .wr_en(host_wr_en), .addr(host_addr), .hit(hit), .win_idx(win_idx)
  );

  csr_win_map #(.WIN_MAP(WIN_MAP)) u_map (.idx(win_idx), .tgt_addr(win_addr));

  csr_cmd_engine u_eng (
    .clk(clk), .rst_n(rst_sync_n), .hit(hit), .wdata(host_wdata),
    .win_addr(win_addr), .ack(reg_ack), .data_q(data_q), .cmd_q(cmd_q)
  );

  assign win_hit = (hit == HIT_WIN);

  always_comb begin
    if (host_rd_addr == DATA_ADDR)     host_rdata = data_q;
    else if (host_rd_addr == CMD_ADDR) host_rdata = cmd_to_word(cmd_q);
    else                               host_rdata = '0;
  end

  assign reg_addr  = cmd_q.addr;
  assign reg_be    = cmd_q.be;
  assign reg_wdata = data_q;
  assign reg_stb   = cmd_q.busy;
endmodule

module csr_write_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        win_hit,
  input logic        step_up,
  input logic        step_dn,
  input logic [15:0] reg_addr,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_wdata,
  input logic        reg_stb,
  input logic        reg_ack
);
  // R4
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb && !reg_ack |=> reg_stb && $stable(reg_addr) && $stable(reg_be) && $stable(reg_wdata));
  // R4
  stb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb && reg_ack |=> !reg_stb);
  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb && reg_ack && step_up && !step_dn |=> reg_addr == $past(reg_addr) + 16'd1);
  // R7
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb && reg_ack && step_dn && !step_up |=> reg_addr == $past(reg_addr) - 16'd1);
  // R8
  step_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb && reg_ack && step_dn && step_up |=> $stable(reg_addr));
  // R9
  win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_stb && win_hit |=> reg_stb && reg_be == 4'hF);
endmodule

bind csr_write_bridge csr_write_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .win_hit(win_hit), .step_up(cmd_q.up), .step_dn(cmd_q.dn),
  .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
  .reg_stb(reg_stb), .reg_ack(reg_ack)
);

// File: tb/csr_write_bridge_bench.sv
module csr_write_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'h00;
  localparam logic [7:0] A_CMD  = 8'h01;
  localparam logic [7:0] A_WIN  = 8'h10;

  function automatic logic [255:0] mk_map();
    logic [255:0] m;
    for (int k = 0; k < 16; k++) m[k*16 +: 16] = 16'(16'h3000 + k * 8);
    return m;
  endfunction
  localparam logic [255:0] BMAP = mk_map();

  // mode 0: data then command, 1: command then data, 2: window (index in cmd[3:0])
  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] cmd;
    logic [31:0] data;
    logic [15:0] exp_addr;
    logic [3:0]  exp_be;
    logic [15:0] exp_after;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 32'h8003_0120, 32'hA5A5_0001, 16'h0120, 4'h3, 16'h0120}, // R3
    '{2'd0, 32'h800F_7FFC, 32'h0BAD_F00D, 16'h7FFC, 4'hF, 16'h7FFC}, // R3
    '{2'd1, 32'h200F_0040, 32'h1111_0002, 16'h0040, 4'hF, 16'h0041}, // R6
    '{2'd1, 32'h100F_0040, 32'h2222_0003, 16'h0040, 4'hF, 16'h003F}, // R7
    '{2'd1, 32'h300F_0040, 32'h3333_0004, 16'h0040, 4'hF, 16'h0040}, // R8
    '{2'd1, 32'h200F_FFFF, 32'h4444_0005, 16'hFFFF, 4'hF, 16'h0000}, // R11
    '{2'd2, 32'h0000_0003, 32'h5555_0006, 16'h3018, 4'hF, 16'h3018}, // R9
    '{2'd2, 32'h0000_000F, 32'h6666_0007, 16'h3078, 4'hF, 16'h3078}  // R9
  };

  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [7:0]  host_addr;
  logic [31:0] host_wdata;
  logic [7:0]  host_rd_addr;
  logic [31:0] host_rdata;
  logic [15:0] reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic        reg_stb;
  logic        reg_ack;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  csr_write_bridge #(.WIN_MAP(BMAP)) u_csr_write_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rd_addr(host_rd_addr), .host_rdata(host_rdata),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_stb(reg_stb), .reg_ack(reg_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    host_rd_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic give_ack();
    @(negedge clk); reg_ack = 1'b1;
    @(negedge clk); reg_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; host_wr_en = 1'b0; host_addr = '0; host_wdata = '0;
    host_rd_addr = '0; reg_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 stb", 32'(reg_stb), 32'd0);
    rd(A_DATA, r); check("R1 data", r, 32'h0);
    rd(A_CMD, r);  check("R1 cmd", r, 32'h0);

    // R2 data write with nothing armed
    host_wr(A_DATA, 32'hCAFE_0000);
    check("R2 stb", 32'(reg_stb), 32'd0);
    rd(A_DATA, r); check("R2 data", r, 32'hCAFE_0000);

    // R5 busy with read-not-write set starts nothing
    host_wr(A_CMD, 32'hC00F_0055);
    check("R5 stb", 32'(reg_stb), 32'd0);
    rd(A_CMD, r); check("R5 cmd", r, 32'h400F_0055);
    // R2 data write with bit 30 set and no stepping
    host_wr(A_DATA, 32'h0000_0077);
    check("R2 stb rnw", 32'(reg_stb), 32'd0);

    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.mode)
        2'd0: begin host_wr(A_DATA, v.data); host_wr(A_CMD, v.cmd); end
        2'd1: begin host_wr(A_CMD, v.cmd); host_wr(A_DATA, v.data); end
        default: host_wr(A_WIN | {4'h0, v.cmd[3:0]}, v.data);
      endcase
      check($sformatf("vec%0d stb", i), 32'(reg_stb), 32'd1);
      check($sformatf("vec%0d addr", i), 32'(reg_addr), 32'(v.exp_addr));
      check($sformatf("vec%0d be", i), 32'(reg_be), 32'(v.exp_be));
      check($sformatf("vec%0d data", i), reg_wdata, v.data);
      repeat (3) @(negedge clk);
      // R4 hold without ack
      check($sformatf("R4 vec%0d hold", i), {reg_stb, 11'd0, reg_be, reg_addr},
            {1'b1, 11'd0, v.exp_be, v.exp_addr});
      give_ack();
      check($sformatf("R4 vec%0d drop", i), 32'(reg_stb), 32'd0);
      rd(A_CMD, r);
      check($sformatf("vec%0d after addr", i), 32'(r[15:0]), 32'(v.exp_after));
      check($sformatf("vec%0d busy", i), 32'(r[31]), 32'd0);
      if (v.mode == 2'd2) check($sformatf("R9 vec%0d flags", i), 32'(r[30:28]), 32'd0);
    end

    // R10 writes while busy are ignored
    host_wr(A_DATA, 32'h1111_2222);
    host_wr(A_CMD, 32'h800F_0200);
    host_wr(A_DATA, 32'hDEAD_0000);
    host_wr(A_CMD, 32'h8001_0999);
    host_wr(A_WIN, 32'hBEEF_0000);
    check("R10 stb", 32'(reg_stb), 32'd1);
    check("R10 addr", 32'(reg_addr), 32'h0200);
    check("R10 be", 32'(reg_be), 32'hF);
    check("R10 data", reg_wdata, 32'h1111_2222);
    give_ack();
    rd(A_DATA, r); check("R10 data rb", r, 32'h1111_2222);
    rd(A_CMD, r);  check("R10 cmd rb", r, 32'h000F_0200);
    check("R10 stb after", 32'(reg_stb), 32'd0);

    finish_run();
  end
endmodule